// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port

This block is the configuration front end of a frequency synthesizer control core. A host drives a serial data line and a serial clock. On each rising serial-clock edge, one bit is shifted LSB first into one of three shift registers. The primary frequency register and the image register are each 20 bits wide. The enhancement register is 8 bits wide. Two control lines choose the target, and a small state machine registers that choice as its current target state.

The divider logic never sees the primary register directly. A rising edge on the secondary-write strobe copies the whole primary register into a 20-bit secondary register in one step. A frequency-select input then picks either the secondary register or the image register as the active frequency word.

The enhancement bits reach downstream logic only while the active-low enhancement control is held low. Under the same condition, the image register's bit 0 is presented on a data-out pin. Shifting the image register therefore reads it back serially on the same serial clock.

All inputs are synchronous to the core clock `clk`. Serial-clock and strobe edges are found by comparing each input with its value one clock earlier.

Top module: `syn_cfg_port`

State machine: the states are `ST_PRI` (shift target is the primary register), `ST_IMG` (the image register) and `ST_ENH` (the enhancement register). The next state is recomputed on every clock:
- Any state goes to `ST_ENH` while `enh_wr` is 1.
- Otherwise any state goes to `ST_IMG` while `img_sel` is 1.
- Otherwise any state goes to `ST_PRI`.
- Reset enters `ST_PRI`.

## Requirements
- R1: Bits are shifted LSB first: after N serial-clock rising edges into an N-bit target, the first bit sent sits in bit 0 and the last bit sent sits in bit N-1.
- R2: A shift happens once for each rising edge of `sclk`, in the clock cycle after `sclk` is first sampled high. Holding `sclk` high or taking it low shifts nothing.
- R3: The shift target is chosen with `enh_wr` taking priority over `img_sel`, which takes priority over the primary register. The choice is registered, so the control lines must be stable for one clock before an `sclk` rising edge.
- R4: Shift registers that are not the current target keep their contents while `sclk` toggles.
- R5: A rising edge of `sec_wr` copies all 20 primary bits into the secondary register. The secondary register changes at no other time, so neither a held strobe nor shifting into the primary register alters it.
- R6: `freq_word` equals the secondary register when `fsel` is 0, and the image register when `fsel` is 1.
- R7: `enh_out` equals the enhancement register while `enh_n` is 0. It is all zero while `enh_n` is 1, and the stored bits are kept.
- R8: `dout` equals image bit 0 while `enh_n` is 0, and is 0 otherwise. Each image shift moves the next image bit onto `dout`.
- R9: While `rst_n` is low at a clock edge, every register clears to zero and `dout`, `enh_out` and `freq_word` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdata | input | 1 | Serial data, LSB first |
| sec_wr | input | 1 | Strobe; its rising edge copies primary into secondary |
| enh_wr | input | 1 | Selects the enhancement register as shift target |
| img_sel | input | 1 | Selects the image register as shift target |
| fsel | input | 1 | Active frequency word: 0 secondary, 1 image |
| enh_n | input | 1 | Active-low gate for the enhancement bits and `dout` |
| freq_word | output | 20 | Active frequency word for the divider logic |
| enh_out | output | 8 | Gated enhancement bits |
| dout | output | 1 | Serial readback of the image register |

## Verification
Several behaviours are checked by assertions on every cycle:
- The secondary register receives the primary value after each strobe edge and holds at all other times.
- Each shift register stays still when it is not enabled.
- The state follows the priority of the control lines.
- The gated outputs stay inactive while `enh_n` is high.
- Reset clears the registers.

Other behaviours can only be shown by the bench scenarios, which shift many computed words and compare whole words:
- End-to-end bit ordering.
- A held `sclk` producing exactly one shift.
- The sequence of readback bits on `dout`.
- Retention of the enhancement bits across a gated period.

// File: rtl/syn_cfg_pkg.sv
package syn_cfg_pkg;
    localparam int FREQ_W = 20;
    localparam int ENH_W  = 8;

    typedef enum logic [1:0] {
        ST_PRI = 2'd0,
        ST_IMG = 2'd1,
        ST_ENH = 2'd2
    } tgt_state_t;
endpackage

// File: rtl/syn_edge_det.sv
module syn_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i];
    end
endmodule

// File: rtl/syn_shift_reg.sv
module syn_shift_reg #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {din, q[W-1:1]};
    end

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q))
        else $error("unselected shift register changed");

    assert_lsb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q[W-1] == $past(din)) && (q[W-2:0] == $past(q[W-1:1])))
        else $error("shift order wrong");
endmodule

// File: rtl/syn_cfg_port.sv
module syn_cfg_port
    import syn_cfg_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int EW = ENH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          sdata,
    input  logic          sec_wr,
    input  logic          enh_wr,
    input  logic          img_sel,
    input  logic          fsel,
    input  logic          enh_n,
    output logic [FW-1:0] freq_word,
    output logic [EW-1:0] enh_out,
    output logic          dout
);
    localparam int NEDGE = 2;

    tgt_state_t    state_q, state_d;
    logic [NEDGE-1:0] edge_in, edge_rise;
    logic          sclk_rise, swr_rise;
    logic          en_pri, en_img, en_enh;
    logic [FW-1:0] pri_q, img_q, sec_q;
    logic [EW-1:0] enh_q;

    assign edge_in   = {sec_wr, sclk};
    assign sclk_rise = edge_rise[0];
    assign swr_rise  = edge_rise[1];

    syn_edge_det #(.N(NEDGE)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (edge_in),
        .rise  (edge_rise)
    );

    // next-state selection: enhancement over image over primary
    always_comb begin
        if (enh_wr)       state_d = ST_ENH;
        else if (img_sel) state_d = ST_IMG;
        else              state_d = ST_PRI;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRI;
        else        state_q <= state_d;
    end

    // outputs of the state machine: shift enables
    always_comb begin
        en_pri = 1'b0;
        en_img = 1'b0;
        en_enh = 1'b0;
        unique case (state_q)
            ST_PRI:  en_pri = sclk_rise;
            ST_IMG:  en_img = sclk_rise;
            ST_ENH:  en_enh = sclk_rise;
            default: ;
        endcase
    end

    syn_shift_reg #(.W(FW)) u_pri (
        .clk(clk), .rst_n(rst_n), .en(en_pri), .din(sdata), .q(pri_q)
    );
    syn_shift_reg #(.W(FW)) u_img (
        .clk(clk), .rst_n(rst_n), .en(en_img), .din(sdata), .q(img_q)
    );
    syn_shift_reg #(.W(EW)) u_enh (
        .clk(clk), .rst_n(rst_n), .en(en_enh), .din(sdata), .q(enh_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        sec_q <= '0;
        else if (swr_rise) sec_q <= pri_q;
    end

    assign freq_word = fsel ? img_q : sec_q;
    assign enh_out   = enh_n ? '0 : enh_q;
    assign dout      = ~enh_n & img_q[0];

    assert_sec_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swr_rise |=> sec_q == $past(pri_q))
        else $error("secondary did not take primary");

    assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swr_rise |=> $stable(sec_q))
        else $error("secondary changed without strobe");

    assert_enh_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enh_wr |=> state_q == ST_ENH)
        else $error("enhancement target lost priority");

    assert_img_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_wr && img_sel) |=> state_q == ST_IMG)
        else $error("image target not chosen");

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> (enh_out == '0) && !dout)
        else $error("gated outputs active while enh_n high");

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (sec_q == '0) && (pri_q == '0) && (img_q == '0) && (enh_q == '0))
        else $error("reset did not clear registers");
endmodule

// File: tb/sim_syn_cfg_port.sv
module sim_syn_cfg_port;
    localparam int PERIOD = 10;
    localparam int FW = 20;
    localparam int EW = 8;

    logic clk = 1'b0;
    logic rst_n, sclk, sdata, sec_wr, enh_wr, img_sel, fsel, enh_n;
    logic [FW-1:0] freq_word;
    logic [EW-1:0] enh_out;
    logic dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    syn_cfg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sec_wr(sec_wr),
        .enh_wr(enh_wr), .img_sel(img_sel), .fsel(fsel), .enh_n(enh_n),
        .freq_word(freq_word), .enh_out(enh_out), .dout(dout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_pulse(input logic b, input int hold);
        @(negedge clk);
        sdata = b;
        sclk = 1'b1;
        wait_n(hold);
        sclk = 1'b0;
        wait_n(2);
    endtask

    task automatic shift_word(input logic [FW-1:0] v, input int n);
        for (int i = 0; i < n; i++) sclk_pulse(v[i], 2);
    endtask

    task automatic strobe();
        @(negedge clk);
        sec_wr = 1'b1;
        wait_n(2);
        sec_wr = 1'b0;
        wait_n(2);
    endtask

    task automatic set_ctl(input logic ew, input logic ld);
        @(negedge clk);
        enh_wr = ew;
        img_sel = ld;
        wait_n(2);
    endtask

    function automatic logic [FW-1:0] pat(input int k);
        return FW'((k * 32'h3A5C7 + 32'h1F) & 32'hFFFFF);
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] prev_sec, img_val, tmp;
        logic [EW-1:0] enh_val;
        rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; sec_wr = 1'b0;
        enh_wr = 1'b0; img_sel = 1'b0; fsel = 1'b0; enh_n = 1'b0;
        wait_n(3);
        // R9 reset state
        chk("R9 freq", 32'(freq_word), 32'h0);
        chk("R9 enh", 32'(enh_out), 32'h0);
        chk("R9 dout", 32'(dout), 32'h0);
        rst_n = 1'b1;
        wait_n(2);

        // R1 R5 primary path, several words
        prev_sec = '0;
        for (int k = 0; k < 6; k++) begin
            set_ctl(1'b0, 1'b0);
            fsel = 1'b0;
            shift_word(pat(k), FW);
            chk("R5 no copy before strobe", 32'(freq_word), 32'(prev_sec));
            strobe();
            chk("R1 R5 copied word", 32'(freq_word), 32'(pat(k)));
            prev_sec = pat(k);
        end
        // R5 held strobe does not recopy
        @(negedge clk); sec_wr = 1'b1; wait_n(3);
        shift_word(pat(9), FW);
        chk("R5 held strobe", 32'(freq_word), 32'(prev_sec));
        @(negedge clk); sec_wr = 1'b0; wait_n(2);
        strobe();
        chk("R5 new edge", 32'(freq_word), 32'(pat(9)));
        prev_sec = pat(9);

        // R3 R6 R4 image path
        img_val = pat(13);
        set_ctl(1'b0, 1'b1);
        shift_word(img_val, FW);
        fsel = 1'b1; wait_n(1);
        chk("R6 R3 image word", 32'(freq_word), 32'(img_val));
        fsel = 1'b0; wait_n(1);
        chk("R6 secondary word", 32'(freq_word), 32'(prev_sec));
        strobe();
        chk("R4 primary held", 32'(freq_word), 32'(pat(9)));

        // R3 priority: enh_wr over img_sel
        enh_val = 8'hA6;
        set_ctl(1'b1, 1'b1);
        shift_word({12'h0, enh_val}, EW);
        enh_n = 1'b0; wait_n(1);
        chk("R3 R1 enh word", 32'(enh_out), 32'(enh_val));
        fsel = 1'b1; wait_n(1);
        chk("R4 image held", 32'(freq_word), 32'(img_val));
        // R7 R8 gating
        enh_n = 1'b1; wait_n(1);
        chk("R7 gated off", 32'(enh_out), 32'h0);
        chk("R8 dout gated", 32'(dout), 32'h0);
        enh_n = 1'b0; wait_n(1);
        chk("R7 retained", 32'(enh_out), 32'(enh_val));

        // R8 serial readback of image
        set_ctl(1'b0, 1'b1);
        for (int i = 0; i < FW; i++) begin
            chk("R8 readback bit", 32'(dout), 32'(img_val[i]));
            sclk_pulse(1'b0, 2);
        end
        chk("R8 image drained", 32'(freq_word), 32'h0);

        // R2 held sclk gives a single shift
        sclk_pulse(1'b1, 6);
        chk("R2 one shift", 32'(freq_word), 32'h80000);
        tmp = 20'h80000;
        // R2 falling edge does nothing
        @(negedge clk); sdata = 1'b1; wait_n(3);
        chk("R2 no shift idle", 32'(freq_word), 32'(tmp));

        // R9 reset mid-use
        @(negedge clk); rst_n = 1'b0; wait_n(2);
        chk("R9 image clear", 32'(freq_word), 32'h0);
        fsel = 1'b0; wait_n(1);
        chk("R9 secondary clear", 32'(freq_word), 32'h0);
        chk("R9 enh clear", 32'(enh_out), 32'h0);
        chk("R9 dout low", 32'(dout), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule